// File: doc/BRIEF.md
# AGC Gain Update Timing Controller

This block paces an automatic gain control loop. It runs a gain update counter whose period, in clock cycles, is the programmed update count plus the settling delay plus a fixed overhead of five cycles. The counter starts once the receiver has been enabled and a programmable start-up delay has elapsed. At the last cycle of each period it strobes a reset to the measurement and peak-count logic. If no gain attack was granted during that period, it also raises a gain recovery pulse.

Attack requests from the detectors are granted at once, except in two cases. A request that arrives while the loop is settling after a previous gain change is dropped. When blocking is enabled, a request that lands in the protected tail of the period is parked and then granted on the first cycle of the next period, which keeps the recovery event strictly periodic. When blocking is disabled, a late grant whose settling time runs past the end of the period holds the expiry back until settling ends. An optional sync pulse, taken from one of several selectable lines, restarts the period so that its phase can be aligned to slot boundaries.

Top module: `agc_update_timer`

## Requirements
- R1: While reset is asserted or `rx_enable` is low, every output (`loop_active`, `attack_grant`, `recovery_pulse`, `meas_reset`, `settling`) is low in that same cycle.
- R2: With start-up delay D, `loop_active` is high from the (D+1)-th clock edge at which `rx_enable` is sampled high. No grant, strobe or settling occurs before that edge.
- R3: With update count C and settling delay S, `meas_reset` is a one-cycle pulse on the last cycle of each period of C+S+5 cycles. The first pulse comes C+S+4 cycles after `loop_active` rises.
- R4: `recovery_pulse` fires together with `meas_reset` only if no attack was granted in that period, including the expiry cycle itself.
- R5: A request on `attack_req` is granted in the same cycle when the loop is active, is not settling, and either blocking is off or the period phase is below C.
- R6: After a grant, `settling` is high for exactly S cycles. A request that arrives while `settling` is high and outside the blocking window is dropped.
- R7: With blocking on, a request at phase C or later (the final S+5 cycles of the period) is held and then granted on the first cycle (phase 0) of the next period.
- R8: With blocking off, if settling is still running at the last phase of a period, the expiry (`meas_reset`, `recovery_pulse`) waits until the first cycle in which `settling` is low.
- R9: With sync enabled, a high level on the line chosen by `cfg_sync_sel` (line index = value of `cfg_sync_sel`) returns the phase to 0 on the next cycle and issues no `meas_reset`. Other lines, and any line while sync is disabled, have no effect.
- R10: Configuration inputs are taken only while `rx_enable` is low. Changes made while enabled do not alter the timing.
- R11: Deasserting `rx_enable` clears the period counter, the parked attack and the delay timers, so a parked request is not granted after re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; starts the timing and clears it when low |
| attack_req | input | 1 | Gain attack request from the detectors |
| sync_in | input | NUM_SYNC | Candidate sync pulse lines |
| cfg_update_cnt | input | CNT_W | Update count C |
| cfg_settle | input | SET_W | Settling delay S in cycles |
| cfg_start_dly | input | START_W | Start-up delay D in cycles |
| cfg_block_en | input | 1 | Enables deferral of late attacks |
| cfg_sync_en | input | 1 | Enables period restart by sync |
| cfg_sync_sel | input | SEL_W | Index of the sync line to use |
| loop_active | output | 1 | Start-up delay elapsed and receiver enabled |
| attack_grant | output | 1 | One-cycle gain attack permission |
| recovery_pulse | output | 1 | One-cycle gain recovery event |
| settling | output | 1 | Settling delay running after a gain change |
| meas_reset | output | 1 | One-cycle reset for measurement and peak counters |

## Verification
The assertions assume that `cfg_update_cnt` is at least 1. With a value of 0, phase 0 falls inside the blocking window and a parked attack would never be granted. They also assume that the configuration is held steady around the edge at which `rx_enable` rises. The stimulus changes configuration only while the receiver has been disabled for at least one edge, with a single exception: one deliberate change while enabled, made to show that it is ignored. It always uses update counts well above zero. Attack and sync stimuli are single-cycle pulses placed at computed phases, so that each defer, drop, hold and restart case is hit on its boundary.

// File: rtl/agc_tmr_pkg.sv
package agc_tmr_pkg;
   // Fixed cycles added to every gain update period on top of count and settle.
   localparam int unsigned PERIOD_OVERHEAD = 5;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/agc_tmr_countdown.sv
module agc_tmr_countdown #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec_en,
   output logic         busy
);
   logic [W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       rem_q <= '0;
      else if (load)                    rem_q <= load_val;
      else if (dec_en && rem_q != '0)   rem_q <= rem_q - 1'b1;
   end

   assign busy = (rem_q != '0);
endmodule

// File: rtl/agc_tmr_period.sv
module agc_tmr_period
   import agc_tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned SET_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             hold,
   input  logic [CNT_W-1:0] upd_cnt,
   input  logic [SET_W-1:0] settle,
   output logic             expiry,
   output logic             in_window
);
   localparam int unsigned PH_W = CNT_W + 2;

   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] last_ph;
   logic            at_last;

   assign last_ph   = PH_W'(upd_cnt) + PH_W'(settle) + PH_W'(PERIOD_OVERHEAD) - PH_W'(1);
   assign at_last   = (phase_q == last_ph);
   assign expiry    = run && at_last && !hold;
   assign in_window = run && (phase_q >= PH_W'(upd_cnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        phase_q <= '0;
      else if (!run)     phase_q <= '0;
      else if (restart)  phase_q <= '0;
      else if (expiry)   phase_q <= '0;
      else if (!at_last) phase_q <= phase_q + 1'b1;
   end
endmodule

// File: rtl/agc_tmr_sync_sel.sv
module agc_tmr_sync_sel #(
   parameter int unsigned NUM_SYNC = 4,
   parameter int unsigned SEL_W    = 2
) (
   input  logic [NUM_SYNC-1:0] sync_in,
   input  logic [SEL_W-1:0]    sel,
   output logic                hit
);
   generate
      if (NUM_SYNC == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^sel;
         assign hit        = sync_in[0];
      end else begin : g_mux
         assign hit = (int'(sel) < int'(NUM_SYNC)) ? sync_in[sel] : 1'b0;
      end
   endgenerate
endmodule

// File: rtl/agc_update_timer.sv
module agc_update_timer
   import agc_tmr_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned SET_W    = 8,
   parameter int unsigned START_W  = 16,
   parameter int unsigned NUM_SYNC = 4,
   localparam int unsigned SEL_W   = sel_width(NUM_SYNC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_enable,
   input  logic                attack_req,
   input  logic [NUM_SYNC-1:0] sync_in,
   input  logic [CNT_W-1:0]    cfg_update_cnt,
   input  logic [SET_W-1:0]    cfg_settle,
   input  logic [START_W-1:0]  cfg_start_dly,
   input  logic                cfg_block_en,
   input  logic                cfg_sync_en,
   input  logic [SEL_W-1:0]    cfg_sync_sel,
   output logic                loop_active,
   output logic                attack_grant,
   output logic                recovery_pulse,
   output logic                settling,
   output logic                meas_reset
);
   generate
      if (SET_W > CNT_W) begin : g_bad_set_w
         $error("SET_W must not exceed CNT_W");
      end
      if (NUM_SYNC < 1) begin : g_bad_sync
         $error("NUM_SYNC must be at least 1");
      end
   endgenerate

   // Shadow configuration, loaded only while the receiver is off
   logic [CNT_W-1:0] cnt_sh;
   logic [SET_W-1:0] set_sh;
   logic             blk_sh;
   logic             syn_en_sh;
   logic [SEL_W-1:0] sel_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_sh    <= '0;
         set_sh    <= '0;
         blk_sh    <= 1'b0;
         syn_en_sh <= 1'b0;
         sel_sh    <= '0;
      end else if (!rx_enable) begin
         cnt_sh    <= cfg_update_cnt;
         set_sh    <= cfg_settle;
         blk_sh    <= cfg_block_en;
         syn_en_sh <= cfg_sync_en;
         sel_sh    <= cfg_sync_sel;
      end
   end

   // Start-up delay
   logic start_busy;
   logic active_q;
   logic run;

   agc_tmr_countdown #(.W(START_W)) start_tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (!rx_enable),
      .load_val (cfg_start_dly),
      .dec_en   (rx_enable),
      .busy     (start_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= rx_enable && (active_q || !start_busy);
   end

   assign run = active_q && rx_enable;

   // Settling delay after each grant
   logic             grant;
   logic             settle_busy;
   logic [SET_W-1:0] settle_val;

   assign settle_val = rx_enable ? set_sh : '0;

   agc_tmr_countdown #(.W(SET_W)) settle_tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (grant || !rx_enable),
      .load_val (settle_val),
      .dec_en   (1'b1),
      .busy     (settle_busy)
   );

   assign settling = settle_busy && rx_enable;

   // Sync line choice and period counter
   logic sync_line;
   logic sync_hit;
   logic expiry;
   logic in_win;

   agc_tmr_sync_sel #(.NUM_SYNC(NUM_SYNC), .SEL_W(SEL_W)) sync_sel_i (
      .sync_in (sync_in),
      .sel     (sel_sh),
      .hit     (sync_line)
   );

   assign sync_hit = run && syn_en_sh && sync_line;

   agc_tmr_period #(.CNT_W(CNT_W), .SET_W(SET_W)) period_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .restart   (sync_hit),
      .hold      (settling),
      .upd_cnt   (cnt_sh),
      .settle    (set_sh),
      .expiry    (expiry),
      .in_window (in_win)
   );

   // Attack arbitration
   logic blocked;
   logic pending_q;
   logic atk_seen_q;

   assign blocked = blk_sh && in_win;
   assign grant   = run && !settling &&
                    ((attack_req && !blocked) || (pending_q && !in_win));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               pending_q <= 1'b0;
      else if (!rx_enable || grant)             pending_q <= 1'b0;
      else if (run && attack_req && blocked)    pending_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    atk_seen_q <= 1'b0;
      else if (!rx_enable)           atk_seen_q <= 1'b0;
      else if (expiry || sync_hit)   atk_seen_q <= 1'b0;
      else if (grant)                atk_seen_q <= 1'b1;
   end

   assign loop_active    = run;
   assign attack_grant   = grant;
   assign meas_reset     = expiry;
   assign recovery_pulse = expiry && !atk_seen_q && !grant;
endmodule

// File: rtl/agc_update_timer_chk.sv
module agc_update_timer_chk #(
   parameter int unsigned SET_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_enable,
   input logic             loop_active,
   input logic             attack_grant,
   input logic             recovery_pulse,
   input logic             meas_reset,
   input logic             settling,
   input logic             in_win,
   input logic             blk_sh,
   input logic [SET_W-1:0] set_sh
);
   p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |-> !(loop_active || attack_grant || recovery_pulse || meas_reset || settling));

   p_idle_before_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_active |-> !(attack_grant || recovery_pulse || meas_reset || settling));

   p_meas_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      meas_reset |=> !meas_reset);

   p_rec_with_meas_r4: assert property (@(posedge clk) disable iff (!rst_n)
      recovery_pulse |-> meas_reset);

   p_rec_not_on_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      recovery_pulse |-> !attack_grant);

   p_no_grant_settling_r6: assert property (@(posedge clk) disable iff (!rst_n)
      settling |-> !attack_grant);

   p_settle_after_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (attack_grant && set_sh != '0) |=> (settling || !rx_enable));

   p_window_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (attack_grant && blk_sh) |-> !in_win);

   p_expiry_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      settling |-> !meas_reset);
endmodule

bind agc_update_timer agc_update_timer_chk #(.SET_W(SET_W)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .rx_enable      (rx_enable),
   .loop_active    (loop_active),
   .attack_grant   (attack_grant),
   .recovery_pulse (recovery_pulse),
   .meas_reset     (meas_reset),
   .settling       (settling),
   .in_win         (in_win),
   .blk_sh         (blk_sh),
   .set_sh         (set_sh)
);

// File: tb/agc_update_timer_tb_top.sv
module agc_update_timer_tb_top;
   localparam int NUM_SYNC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_enable = 1'b0;
   logic        attack_req = 1'b0;
   logic [3:0]  sync_in = '0;
   logic [15:0] cfg_update_cnt = 16'd10;
   logic [7:0]  cfg_settle = 8'd3;
   logic [15:0] cfg_start_dly = 16'd4;
   logic        cfg_block_en = 1'b1;
   logic        cfg_sync_en = 1'b0;
   logic [1:0]  cfg_sync_sel = 2'd2;
   logic        loop_active, attack_grant, recovery_pulse, settling, meas_reset;

   agc_update_timer #(.CNT_W(16), .SET_W(8), .START_W(16), .NUM_SYNC(NUM_SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .attack_req(attack_req),
      .sync_in(sync_in), .cfg_update_cnt(cfg_update_cnt), .cfg_settle(cfg_settle),
      .cfg_start_dly(cfg_start_dly), .cfg_block_en(cfg_block_en), .cfg_sync_en(cfg_sync_en),
      .cfg_sync_sel(cfg_sync_sel), .loop_active(loop_active), .attack_grant(attack_grant),
      .recovery_pulse(recovery_pulse), .settling(settling), .meas_reset(meas_reset)
   );

   always #2 clk = ~clk;

   typedef struct { int cyc; string req; } exp_t;
   exp_t  q_meas[$];
   exp_t  q_rec[$];
   exp_t  q_grant[$];
   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   string cur_req = "R1";

   always @(posedge clk) cyc <= cyc + 1;

   task automatic go_to(input int n);
      while (cyc < n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic push(input int kind, input int c, input string req);
      exp_t e;
      e.cyc = c;
      e.req = req;
      case (kind)
         0: q_meas.push_back(e);
         1: q_rec.push_back(e);
         default: q_grant.push_back(e);
      endcase
   endtask

   task automatic sb_match(input int kind);
      exp_t  e;
      bit    empty;
      string nm;
      case (kind)
         0: begin nm = "meas_reset"; empty = (q_meas.size() == 0); if (!empty) e = q_meas.pop_front(); end
         1: begin nm = "recovery_pulse"; empty = (q_rec.size() == 0); if (!empty) e = q_rec.pop_front(); end
         default: begin nm = "attack_grant"; empty = (q_grant.size() == 0); if (!empty) e = q_grant.pop_front(); end
      endcase
      checks++;
      if (empty) begin
         errors++;
         $display("FAIL %s: unexpected %s at cycle %0d, expected none", cur_req, nm, cyc);
      end else if (e.cyc != cyc) begin
         errors++;
         $display("FAIL %s: %s at cycle %0d, expected cycle %0d", e.req, nm, cyc, e.cyc);
      end
   endtask

   // Monitor: every observed pulse is matched against the expected queue
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (meas_reset)     sb_match(0);
         if (recovery_pulse) sb_match(1);
         if (attack_grant)   sb_match(2);
      end
   end

   task automatic drain();
      exp_t e;
      checks += 3;
      while (q_meas.size() > 0) begin
         e = q_meas.pop_front(); errors++;
         $display("FAIL %s: meas_reset none, expected cycle %0d", e.req, e.cyc);
      end
      while (q_rec.size() > 0) begin
         e = q_rec.pop_front(); errors++;
         $display("FAIL %s: recovery_pulse none, expected cycle %0d", e.req, e.cyc);
      end
      while (q_grant.size() > 0) begin
         e = q_grant.pop_front(); errors++;
         $display("FAIL %s: attack_grant none, expected cycle %0d", e.req, e.cyc);
      end
   endtask

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: %s = %b, expected %b (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic chk_quiet(input string req);
      chk(loop_active | attack_grant | recovery_pulse | settling | meas_reset, 1'b0, req, "any output");
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // Base configuration: C=10, S=3, period P=18
   localparam int C = 10;
   localparam int S = 3;
   localparam int P = C + S + 5;

   initial begin
      int e;
      int a;
      int e2;
      int a2;
      // R1 reset state
      #1;
      repeat (3) @(negedge clk);
      chk_quiet("R1");
      @(posedge clk); #1;
      rst_n = 1'b1;
      go_to(cyc + 2);

      // Scenario 1: R2 start-up, R3 period, R4 recovery, R10 config frozen, R1 disable
      cur_req = "R3";
      e = cyc + 1;
      go_to(e); rx_enable = 1'b1;
      a = e + 4 + 1;
      for (int k = 0; k < 3; k++) begin
         push(0, a + P - 1 + k * P, "R3 R10");
         push(1, a + P - 1 + k * P, "R4");
      end
      go_to(e + 1); cfg_update_cnt = 16'd3; cfg_settle = 8'd0;
      go_to(a - 1); @(negedge clk); chk(loop_active, 1'b0, "R2", "loop_active before delay");
      go_to(a);     @(negedge clk); chk(loop_active, 1'b1, "R2", "loop_active after delay");
      go_to(a + 3 * P + 2); rx_enable = 1'b0;
      @(negedge clk); chk_quiet("R1");
      go_to(a + 3 * P + 4); @(negedge clk); chk_quiet("R1");
      cfg_update_cnt = 16'd10; cfg_settle = 8'd3;
      drain();

      // Scenario 2: R5 immediate grant, R6 settling and dropped request, R9 sync disabled
      cur_req = "R6";
      e = cyc + 2;
      go_to(e); rx_enable = 1'b1;
      a = e + 5;
      push(2, a + 2, "R5");
      push(0, a + P - 1, "R3");
      push(0, a + 2 * P - 1, "R9");
      push(1, a + 2 * P - 1, "R4");
      go_to(a + 2); attack_req = 1'b1;
      @(negedge clk); chk(settling, 1'b0, "R6", "settling in grant cycle");
      go_to(a + 3); attack_req = 1'b0;
      @(negedge clk); chk(settling, 1'b1, "R6", "settling first cycle");
      go_to(a + 4); attack_req = 1'b1;
      go_to(a + 5); attack_req = 1'b0;
      @(negedge clk); chk(settling, 1'b1, "R6", "settling last cycle");
      go_to(a + 6); @(negedge clk); chk(settling, 1'b0, "R6", "settling after S cycles");
      go_to(a + 7); sync_in = 4'b0100;
      go_to(a + 8); sync_in = 4'b0000;
      go_to(a + 2 * P + 2); rx_enable = 1'b0;
      go_to(cyc + 2);
      drain();

      // Scenario 3: R7 deferral in blocking window, boundary just before it
      cur_req = "R7";
      e = cyc + 2;
      go_to(e); rx_enable = 1'b1;
      a = e + 5;
      push(0, a + P - 1, "R7");
      push(1, a + P - 1, "R4");
      push(2, a + P, "R7");
      push(2, a + P + C - 1, "R5");
      push(0, a + 2 * P - 1, "R7");
      go_to(a + C); attack_req = 1'b1;
      go_to(a + C + 1); attack_req = 1'b0;
      go_to(a + P + C - 1); attack_req = 1'b1;
      go_to(a + P + C); attack_req = 1'b0;
      go_to(a + 2 * P + 2); rx_enable = 1'b0;
      go_to(cyc + 2);
      drain();

      // Scenario 4: R8 blocking off, late grant holds expiry
      cur_req = "R8";
      cfg_block_en = 1'b0;
      e = cyc + 2;
      go_to(e); rx_enable = 1'b1;
      a = e + 5;
      push(2, a + P - 2, "R8");
      push(0, a + P - 1 + S, "R8");
      push(0, a + 2 * P + S - 1, "R8");
      push(1, a + 2 * P + S - 1, "R4");
      go_to(a + P - 2); attack_req = 1'b1;
      go_to(a + P - 1); attack_req = 1'b0;
      go_to(a + 2 * P + S + 1); rx_enable = 1'b0;
      cfg_block_en = 1'b1;
      go_to(cyc + 2);
      drain();

      // Scenario 5: R9 sync restart on selected line only
      cur_req = "R9";
      cfg_sync_en = 1'b1;
      e = cyc + 2;
      go_to(e); rx_enable = 1'b1;
      a = e + 5;
      push(0, a + P + 5, "R9");
      push(1, a + P + 5, "R9");
      go_to(a + 5);  sync_in = 4'b0100;
      go_to(a + 6);  sync_in = 4'b0000;
      go_to(a + 10); sync_in = 4'b0010;
      go_to(a + 11); sync_in = 4'b0000;
      go_to(a + P + 7); rx_enable = 1'b0;
      cfg_sync_en = 1'b0;
      go_to(cyc + 2);
      drain();

      // Scenario 6: R11 disable drops a parked attack
      cur_req = "R11";
      cfg_start_dly = 16'd0;
      e = cyc + 2;
      go_to(e); rx_enable = 1'b1;
      a = e + 1;
      go_to(a + C); attack_req = 1'b1;
      go_to(a + C + 1); attack_req = 1'b0;
      go_to(a + C + 2); rx_enable = 1'b0;
      e2 = a + C + 5;
      a2 = e2 + 1;
      push(0, a2 + P - 1, "R11");
      push(1, a2 + P - 1, "R11");
      go_to(e2); rx_enable = 1'b1;
      go_to(a2 + P + 1); rx_enable = 1'b0;
      go_to(cyc + 2);
      drain();

      // Scenario 7: R3 long period, 18423 + 4 + 5 = 18432 cycles
      cur_req = "R3";
      cfg_update_cnt = 16'd18423; cfg_settle = 8'd4;
      e = cyc + 2;
      go_to(e); rx_enable = 1'b1;
      a = e + 1;
      push(0, a + 18431, "R3");
      push(1, a + 18431, "R4");
      go_to(a + 18433); rx_enable = 1'b0;
      go_to(cyc + 2);
      drain();

      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: run not finished at cycle %0d, expected completion", cyc);
         summary();
         $finish;
      end
   end
endmodule